// File: doc/BRIEF.md
# Register-List Block Transfer Sequencer

This block carries out a multi-register load or store described by a 16-bit register list. A request supplies the base address and the number of the base register, the list, and flags that select pre-stepping or post-stepping, upward or downward addressing, load or store, base writeback and the privileged S option. The block then handles one listed register per accepted memory beat. Each beat is a 32-bit access at an address that moves by four bytes. Each loaded word becomes a register-file write, tagged with whether the user-bank copy is meant. The memory, the register file and the mode logic sit outside the block.

The request port is valid/ready. `req_ready` is high only while the block is idle, and a request is taken on a clock edge where both `req_valid` and `req_ready` are high. The memory port is valid/ready too. Once `mem_valid` rises, address, direction and store data hold steady until the edge where `mem_ready` is high. For a load, `mem_rdata` must be valid in that same cycle. The register-file read port is combinational. Completion is shown by a one-cycle `done` pulse. Writeback, restore, flush, error and the loaded-register count are valid during that pulse.

Top module: `blk_xfer_seq`

## Requirements
- R1: `req_ready` is 1 after reset and whenever the block is idle, and 0 from the cycle after a request is accepted until `done`. `done` is a single-cycle pulse after which the block is idle again.
- R2: With post-stepping, the first access goes to the base address. With pre-stepping, it goes to base+4 (upward) or base-4 (downward). Each later access is the previous address plus 4 (upward) or minus 4 (downward), wrapping modulo 2^32.
- R3: Upward transfers visit list bits 0 to 15 in rising order. Downward transfers visit them from 15 down to 0. There is exactly one access per set bit, and clear bits are skipped.
- R4: While `mem_valid` is high and `mem_ready` is low, address and direction stay unchanged. On each accepted load beat, `rf_wr_en` is high in that same cycle, with `rf_wr_idx` set to the register and `rf_wr_data` set to `mem_rdata`. `mem_write` is 1 for stores and 0 for loads.
- R5: A store of a register other than 15 writes the value returned on `rf_rd_data` for `rf_rd_idx`. A store of register 15 writes `req_pc` + 12.
- R6: At `done`, `wb_en` is 1 when writeback was requested, the list was non-empty, there was no error, and this was not a load whose list holds the base register. `wb_idx` is the base register number, and `wb_data` is the base moved by 4 times the number of listed registers in the chosen direction.
- R7: The user-bank tag on `rf_rd_user` and `rf_wr_user` is 1 exactly when S is set and the transfer is either a store or a load whose list lacks register 15.
- R8: At `done`, `flush` is 1 for a load whose list holds register 15. `psr_restore` is 1 only for such a load with S set, and it is never 1 without `flush`.
- R9: A request with S set while `req_unpriv` is 1 makes no memory access and ends with `done` and `err` both high. In that cycle `wb_en`, `flush` and `psr_restore` are 0.
- R10: At `done`, `load_cycles` equals the number of registers loaded (one internal cycle each). It is 0 for stores.
- R11: An empty list makes no memory access and ends with `done`, with `wb_en` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_base | input | 32 | Base address value |
| req_base_idx | input | 4 | Base register number |
| req_list | input | 16 | Register list, bit n = register n |
| req_pre | input | 1 | 1: step before each access, 0: after |
| req_up | input | 1 | 1: upward (+4), 0: downward (-4) |
| req_load | input | 1 | 1: load, 0: store |
| req_wb | input | 1 | Base writeback requested |
| req_s | input | 1 | Privileged S option |
| req_unpriv | input | 1 | Current mode is unprivileged (user or system) |
| req_pc | input | 32 | Instruction address |
| mem_valid | output | 1 | Memory beat offered |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_write | output | 1 | 1: store beat, 0: load beat |
| mem_addr | output | 32 | Beat address |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Load data, valid with `mem_ready` |
| rf_rd_idx | output | 4 | Register to read for a store |
| rf_rd_user | output | 1 | Read the user-bank copy |
| rf_rd_data | input | 32 | Register value read |
| rf_wr_en | output | 1 | Register write strobe |
| rf_wr_idx | output | 4 | Register written |
| rf_wr_user | output | 1 | Write the user-bank copy |
| rf_wr_data | output | 32 | Value written |
| done | output | 1 | Completion pulse |
| err | output | 1 | Illegal S use, valid with `done` |
| wb_en | output | 1 | Base writeback, valid with `done` |
| wb_idx | output | 4 | Base register to write |
| wb_data | output | 32 | Final stepped address |
| psr_restore | output | 1 | Saved-to-current status copy request |
| flush | output | 1 | Pipeline flush request |
| load_cycles | output | 5 | Internal cycles added by loads |

## Verification
The bench aims at the cases where a single wrong rule is silent in the common path. A downward store that holds register 15 would put the PC value at the wrong address if the order were reversed, or the wrong value if the +12 offset were missed. A pre-step upward walk across address 0xFFFFFFFC would show a carry bug or the wrong first address. A load with the base register in its list would still produce a writeback if the cancel rule were lost. The S loads with and without register 15, plus the S store, separate the user-bank tag from the restore request. A flipped condition would show up as a wrong tag on each beat or as a restore pulse without a flush. Random memory stalls test that beats hold steady and that no beat is lost or doubled.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;
  localparam int unsigned NREG = 16;
  localparam int unsigned IW   = $clog2(NREG);
  localparam int unsigned AW   = 32;
  localparam int unsigned STEP = 4;
  localparam int unsigned PC_OFS = 12;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/blk_xfer_pick.sv
// Selects the next register still pending in the list: the lowest set bit
// when walking upward, the highest set bit when walking downward.
module blk_xfer_pick #(
  parameter int unsigned N  = 16,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  pend,
  input  logic          up,
  output logic [IW-1:0] idx,
  output logic          any
);
  logic [IW-1:0] lo_idx, hi_idx;

  always_comb begin
    lo_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) lo_idx = IW'(i);
    end
  end

  always_comb begin
    hi_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (pend[i]) hi_idx = IW'(i);
    end
  end

  assign any = |pend;
  assign idx = up ? lo_idx : hi_idx;
endmodule

// File: rtl/blk_xfer_addr.sv
// Produces the address of the current beat and the address after stepping.
module blk_xfer_addr #(
  parameter int unsigned AW   = 32,
  parameter int unsigned STEP = 4
) (
  input  logic [AW-1:0] cur,
  input  logic          up,
  input  logic          pre,
  output logic [AW-1:0] beat_addr,
  output logic [AW-1:0] next_addr
);
  logic [AW-1:0] stepped;

  assign stepped   = up ? (cur + AW'(STEP)) : (cur - AW'(STEP));
  assign beat_addr = pre ? stepped : cur;
  assign next_addr = stepped;
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
  import blk_xfer_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [AW-1:0]  req_base,
  input  logic [IW-1:0]  req_base_idx,
  input  logic [NREG-1:0] req_list,
  input  logic           req_pre,
  input  logic           req_up,
  input  logic           req_load,
  input  logic           req_wb,
  input  logic           req_s,
  input  logic           req_unpriv,
  input  logic [AW-1:0]  req_pc,
  output logic           mem_valid,
  input  logic           mem_ready,
  output logic           mem_write,
  output logic [AW-1:0]  mem_addr,
  output logic [31:0]    mem_wdata,
  input  logic [31:0]    mem_rdata,
  output logic [IW-1:0]  rf_rd_idx,
  output logic           rf_rd_user,
  input  logic [31:0]    rf_rd_data,
  output logic           rf_wr_en,
  output logic [IW-1:0]  rf_wr_idx,
  output logic           rf_wr_user,
  output logic [31:0]    rf_wr_data,
  output logic           done,
  output logic           err,
  output logic           wb_en,
  output logic [IW-1:0]  wb_idx,
  output logic [AW-1:0]  wb_data,
  output logic           psr_restore,
  output logic           flush,
  output logic [IW:0]    load_cycles
);
  localparam logic [IW-1:0] PC_IDX = IW'(NREG - 1);

  seq_state_e     state_q;
  logic [NREG-1:0] pend_q;
  logic [AW-1:0]  addr_q, pc_q;
  logic [IW-1:0]  base_idx_q;
  logic           pre_q, up_q, load_q, wb_q, s_q, err_q;
  logic           pc_in_q, base_in_q, nonempty_q;
  logic [IW:0]    lcnt_q;

  logic [IW-1:0]  cur_idx;
  logic           pend_any;
  logic [AW-1:0]  beat_addr, next_addr;
  logic           accept, beat_done, last_beat, user_bank;
  logic [NREG-1:0] pend_after;

  blk_xfer_pick #(.N(NREG), .IW(IW)) pick_i (
    .pend (pend_q),
    .up   (up_q),
    .idx  (cur_idx),
    .any  (pend_any)
  );

  blk_xfer_addr #(.AW(AW), .STEP(STEP)) addr_i (
    .cur       (addr_q),
    .up        (up_q),
    .pre       (pre_q),
    .beat_addr (beat_addr),
    .next_addr (next_addr)
  );

  assign accept     = req_valid && req_ready;
  assign beat_done  = mem_valid && mem_ready;
  assign pend_after = pend_q & ~(NREG'(1) << cur_idx);
  assign last_beat  = (pend_after == '0);
  // user bank for stores always, for loads only without the PC in the list
  assign user_bank  = s_q && (!load_q || !pc_in_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      pend_q     <= '0;
      addr_q     <= '0;
      pc_q       <= '0;
      base_idx_q <= '0;
      pre_q      <= 1'b0;
      up_q       <= 1'b0;
      load_q     <= 1'b0;
      wb_q       <= 1'b0;
      s_q        <= 1'b0;
      err_q      <= 1'b0;
      pc_in_q    <= 1'b0;
      base_in_q  <= 1'b0;
      nonempty_q <= 1'b0;
      lcnt_q     <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            addr_q     <= req_base;
            pc_q       <= req_pc;
            base_idx_q <= req_base_idx;
            pre_q      <= req_pre;
            up_q       <= req_up;
            load_q     <= req_load;
            wb_q       <= req_wb;
            s_q        <= req_s;
            err_q      <= req_s && req_unpriv;
            pc_in_q    <= req_list[PC_IDX];
            base_in_q  <= req_list[req_base_idx];
            nonempty_q <= |req_list;
            lcnt_q     <= '0;
            if ((req_s && req_unpriv) || (req_list == '0)) begin
              pend_q  <= '0;
              state_q <= ST_FIN;
            end else begin
              pend_q  <= req_list;
              state_q <= ST_XFER;
            end
          end
        end
        ST_XFER: begin
          if (beat_done) begin
            pend_q <= pend_after;
            addr_q <= next_addr;
            if (load_q) lcnt_q <= lcnt_q + 1'b1;
            if (last_beat) state_q <= ST_FIN;
          end
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready  = (state_q == ST_IDLE);
  assign mem_valid  = (state_q == ST_XFER) && pend_any;
  assign mem_write  = !load_q;
  assign mem_addr   = beat_addr;
  assign mem_wdata  = (cur_idx == PC_IDX) ? (pc_q + AW'(PC_OFS)) : rf_rd_data;
  assign rf_rd_idx  = cur_idx;
  assign rf_rd_user = user_bank;
  assign rf_wr_en   = beat_done && load_q;
  assign rf_wr_idx  = cur_idx;
  assign rf_wr_user = user_bank;
  assign rf_wr_data = mem_rdata;

  assign done        = (state_q == ST_FIN);
  assign err         = done && err_q;
  assign wb_en       = done && !err_q && nonempty_q && wb_q && !(load_q && base_in_q);
  assign wb_idx      = base_idx_q;
  assign wb_data     = addr_q;
  assign flush       = done && !err_q && load_q && pc_in_q;
  assign psr_restore = done && !err_q && load_q && pc_in_q && s_q;
  assign load_cycles = lcnt_q;

  // Beat held under back-pressure
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write));

  // Consecutive beats step by four in the chosen direction
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready |=> !mem_valid ||
      (mem_addr == (up_q ? $past(mem_addr) + AW'(STEP) : $past(mem_addr) - AW'(STEP))));

  // Selected register is still pending
  p_pick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> pend_q[cur_idx]);

  // Register writes only on accepted load beats
  p_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_en |-> mem_valid && mem_ready && !mem_write);

  // Restore never without flush
  p_restore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    psr_restore |-> flush);

  // Error ends with no side effects
  p_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done && !wb_en && !flush && !psr_restore);

  // Done is one cycle, then idle
  p_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && req_ready);
endmodule

// File: tb/blk_xfer_seq_tb_top.sv
module blk_xfer_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_base = '0;
  logic [3:0]  req_base_idx = '0;
  logic [15:0] req_list = '0;
  logic        req_pre = 1'b0, req_up = 1'b0, req_load = 1'b0, req_wb = 1'b0;
  logic        req_s = 1'b0, req_unpriv = 1'b0;
  logic [31:0] req_pc = '0;
  logic        mem_valid, mem_write;
  logic        mem_ready = 1'b1;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  rf_rd_idx, rf_wr_idx, wb_idx;
  logic        rf_rd_user, rf_wr_en, rf_wr_user;
  logic [31:0] rf_rd_data, rf_wr_data, wb_data;
  logic        done, err, wb_en, psr_restore, flush;
  logic [4:0]  load_cycles;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit stall = 0;
  bit seen_done = 0;

  // expected beats
  logic [31:0] q_addr[$];
  logic [31:0] q_data[$];
  logic [3:0]  q_idx[$];
  bit          e_load, e_user, e_err, e_wb, e_restore, e_flush;
  logic [31:0] e_wbdata;
  logic [3:0]  e_wbidx;
  int          e_lc;

  always #5 clk = ~clk;

  function automatic logic [31:0] regval(logic [3:0] idx, logic user);
    return 32'h1100_0000 * idx + (user ? 32'h55 : 32'h0) + 32'h7;
  endfunction

  assign mem_rdata  = mem_addr ^ 32'hA5A5_0F0F;
  assign rf_rd_data = regval(rf_rd_idx, rf_rd_user);

  blk_xfer_seq dut_i (.*);

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: drive ready, then sample away from the edge
  always @(negedge clk) begin
    if (rst_n) begin
      mem_ready = stall ? (lfsr[0] | lfsr[3]) : 1'b1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      #1;
      if (mem_valid && mem_ready) begin
        if (q_addr.size() == 0) begin
          check(0, "R3 extra beat", mem_addr, 0);
        end else begin
          logic [31:0] ea, ed;
          logic [3:0] ei;
          ea = q_addr.pop_front(); ed = q_data.pop_front(); ei = q_idx.pop_front();
          check(mem_addr == ea, "R2/R3 beat address", mem_addr, ea);
          check(mem_write == !e_load, "R4 beat direction", mem_write, !e_load);
          check(rf_rd_user == e_user, "R7 user tag", rf_rd_user, e_user);
          if (e_load) begin
            check(rf_wr_en && rf_wr_idx == ei && rf_wr_data == ed && rf_wr_user == e_user,
                  "R4 register write", {rf_wr_en, rf_wr_user, rf_wr_idx, rf_wr_data[23:0]},
                  {1'b1, e_user, ei, ed[23:0]});
          end else begin
            check(mem_wdata == ed, "R5 store data", mem_wdata, ed);
          end
        end
      end else if (rf_wr_en) begin
        check(0, "R4 write without beat", 1, 0);
      end
      if (done) begin
        check(q_addr.size() == 0, "R3 missing beats", q_addr.size(), 0);
        check(err == e_err, "R9 err", err, e_err);
        check(wb_en == e_wb, "R6 wb_en", wb_en, e_wb);
        if (e_wb) check(wb_data == e_wbdata && wb_idx == e_wbidx, "R6 wb value",
                        wb_data, e_wbdata);
        check(flush == e_flush, "R8 flush", flush, e_flush);
        check(psr_restore == e_restore, "R8 restore", psr_restore, e_restore);
        check(load_cycles == e_lc, "R10 load cycles", load_cycles, e_lc);
        seen_done = 1;
      end
    end
  end

  task automatic run(logic [31:0] base, logic [3:0] bidx, logic [15:0] list, bit pre,
                     bit up, bit load, bit wb, bit s, bit unpriv, logic [31:0] pc, bit stl);
    logic [31:0] a;
    int n;
    stall = stl;
    e_load = load;
    e_user = s && (!load || !list[15]);
    e_err = s && unpriv;
    e_flush = !e_err && load && list[15];
    e_restore = e_flush && s;
    a = base; n = 0;
    if (!e_err) begin
      for (int i = 0; i < 16; i++) begin
        int r;
        r = up ? i : 15 - i;
        if (list[r]) begin
          logic [31:0] ba;
          n++;
          if (pre) a = up ? a + 4 : a - 4;
          ba = a;
          if (!pre) a = up ? a + 4 : a - 4;
          q_addr.push_back(ba);
          q_idx.push_back(4'(r));
          if (load) q_data.push_back(ba ^ 32'hA5A5_0F0F);
          else q_data.push_back(r == 15 ? pc + 12 : regval(4'(r), e_user));
        end
      end
    end
    e_lc = load ? n : 0;
    e_wb = !e_err && n > 0 && wb && !(load && list[bidx]);
    e_wbdata = a;
    e_wbidx = bidx;
    seen_done = 0;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready when idle", req_ready, 1);
    req_valid = 1; req_base = base; req_base_idx = bidx; req_list = list;
    req_pre = pre; req_up = up; req_load = load; req_wb = wb; req_s = s;
    req_unpriv = unpriv; req_pc = pc;
    @(negedge clk);
    req_valid = 0;
    #2;
    if (!seen_done) check(req_ready == 1'b0, "R1 busy after accept", req_ready, 0);
    while (!seen_done) @(negedge clk);
    @(negedge clk);
    #2;
    check(req_ready == 1'b1 && !done, "R1 idle after done", req_ready, 1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog: actual %0d expected <100000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    check(req_ready == 1'b1 && !mem_valid && !done, "R1 reset state",
          {req_ready, mem_valid, done}, 3'b100);
    rst_n = 1;
    // R3 upward post-step load, writeback
    run(32'h0000_1000, 4'd13, 16'h00F0, 0, 1, 1, 1, 0, 0, 32'h100, 0);
    // R5 downward pre-step store incl. PC
    run(32'h0000_2000, 4'd13, 16'h8003, 1, 0, 0, 1, 0, 0, 32'h0000_0400, 0);
    // R6 load with base in list cancels writeback
    run(32'h0000_3000, 4'd2, 16'h0006, 0, 1, 1, 1, 0, 0, 32'h0, 1);
    // R7 S store uses user bank
    run(32'h0000_4000, 4'd13, 16'h6001, 1, 1, 0, 1, 1, 0, 32'h0, 1);
    // R8 S load with PC restores and flushes
    run(32'h0000_5000, 4'd13, 16'h8010, 0, 0, 1, 1, 1, 0, 32'h0, 0);
    // R8 plain load of PC flushes only
    run(32'h0000_6000, 4'd13, 16'h8000, 1, 0, 1, 0, 0, 0, 32'h0, 1);
    // R9 S in unprivileged mode
    run(32'h0000_7000, 4'd13, 16'h00FF, 0, 1, 1, 1, 1, 1, 32'h0, 0);
    // R11 empty list
    run(32'h0000_8000, 4'd13, 16'h0000, 0, 1, 1, 1, 0, 0, 32'h0, 0);
    // R2 wrap past zero
    run(32'hFFFF_FFF8, 4'd0, 16'h0007, 1, 1, 0, 1, 0, 0, 32'h0, 0);
    // R7 S load without PC uses user bank, R10 count
    run(32'h0000_9000, 4'd13, 16'h5A5A, 1, 1, 1, 1, 1, 0, 32'h0, 1);
    // R4 full list store under heavy stall, post-step downward
    run(32'h0001_0000, 4'd13, 16'hFFFF, 0, 0, 0, 1, 0, 0, 32'h0000_0800, 1);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule